// File: doc/BRIEF.md
# Conditional ALU with Flag Update

This block is the single-cycle data-processing stage of a 32-bit integer pipeline. Each cycle it receives an instruction's 4-bit operation code, 4-bit condition code, a set-flags bit, a first operand, a second operand that has already passed through the operand shifter, and that shifter's carry-out. It keeps the negative, zero, carry and overflow flags in a register of its own and checks the condition code against them. When the condition holds, the block produces a result, a write enable for the destination register and, where the instruction asks for it, new flags.

The operations are: sixteen arithmetic, logical, move and compare/test operations. They are add, add with carry, subtract, subtract with carry, reverse subtract, reverse subtract with carry, AND, OR, exclusive OR, bit clear, move, move inverted, and four operations that only set flags. The result and the write enable are combinational. The flags register loads at the next rising clock edge, so the following instruction sees the new flags.

Top module: `dp_cond_alu`

## Requirements
- R1: Single-flag conditions: code 0 passes when Z=1, 1 when Z=0, 2 when C=1, 3 when C=0, 4 when N=1, 5 when N=0, 6 when V=1, 7 when V=0.
- R2: Compound conditions: code 8 passes when C=1 and Z=0, 9 when C=0 or Z=1, 10 when N=V, 11 when N!=V, 12 when Z=0 and N=V, 13 when Z=1 or N!=V. Code 14 always passes and code 15 never passes.
- R3: When the condition fails, the write enable is low and the flags keep their value across the clock edge.
- R4: For operations other than compare/test, a passing instruction updates the flags only when set_flags is 1. The compare/test operations (opcodes 8 to 11) always update the flags and never assert the write enable. All other passing operations assert it.
- R5: On a flag update, N is bit 31 of the result and Z is 1 exactly when the whole result is zero. The flags output is ordered {N,Z,C,V}.
- R6: Arithmetic opcodes compute: 2 A-B, 3 B-A, 4 A+B, 5 A+B+C, 6 A-B-(1-C), 7 B-A-(1-C). C becomes the adder carry-out, so a subtraction sets C=1 when no borrow occurs.
- R7: For arithmetic and arithmetic-compare opcodes, V becomes 1 on two's-complement overflow. For all other opcodes, V is left unchanged.
- R8: Logical opcodes compute: 0 A AND B, 1 A XOR B, 12 A OR B, 13 B, 14 A AND NOT B, 15 NOT B. C takes the shifter carry-out.
- R9: Compare/test opcodes set flags from 8 A AND B and 9 A XOR B (C from the shifter), and from 10 A-B and 11 A+B (C and V from the adder).
- R10: After reset all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_code | input | 4 | Condition code of the instruction |
| opcode | input | 4 | Operation code of the instruction |
| set_flags | input | 1 | Request a flag update |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, after the shifter |
| shift_carry | input | 1 | Carry-out of the operand shifter |
| result | output | 32 | Operation result; meaningful only when the write enable is high |
| rd_write | output | 1 | Destination write enable |
| flags | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The bench runs a chain of instructions in which each instruction's condition depends on the flags left by the one before it. A design that evaluated a condition against the wrong flag, or that let a failed instruction change the flags, sends the chain off course and misses later expected values. The carry-dependent operations are run with the stored carry both set and clear. A design that used the carry directly instead of its inverse in subtract-with-carry would be off by one. Signed overflow is provoked in both directions. Logical operations are issued after overflow was set, so a design that cleared V on them would show it. Compare operations with set_flags low must still load flags and never write. Code 15 must block even with set_flags high.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND    = 4'd0,
      OP_XOR    = 4'd1,
      OP_SUB    = 4'd2,
      OP_RSUB   = 4'd3,
      OP_ADD    = 4'd4,
      OP_ADDC   = 4'd5,
      OP_SUBC   = 4'd6,
      OP_RSUBC  = 4'd7,
      OP_TSTAND = 4'd8,
      OP_TSTXOR = 4'd9,
      OP_CMPSUB = 4'd10,
      OP_CMPADD = 4'd11,
      OP_OR     = 4'd12,
      OP_MOVE   = 4'd13,
      OP_CLR    = 4'd14,
      OP_MOVN   = 4'd15
   } op_e;

   typedef enum logic [3:0] {
      COND_EQ     = 4'd0,
      COND_NE     = 4'd1,
      COND_UHS    = 4'd2,
      COND_ULO    = 4'd3,
      COND_NEG    = 4'd4,
      COND_POS    = 4'd5,
      COND_OVF    = 4'd6,
      COND_NOVF   = 4'd7,
      COND_UHI    = 4'd8,
      COND_ULS    = 4'd9,
      COND_SGE    = 4'd10,
      COND_SLT    = 4'd11,
      COND_SGT    = 4'd12,
      COND_SLE    = 4'd13,
      COND_ALWAYS = 4'd14,
      COND_NEVER  = 4'd15
   } cond_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   function automatic logic op_is_compare(input op_e op);
      return (op == OP_TSTAND) || (op == OP_TSTXOR) ||
             (op == OP_CMPSUB) || (op == OP_CMPADD);
   endfunction

   function automatic logic op_is_arith(input op_e op);
      unique case (op)
         OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC, OP_RSUBC,
         OP_CMPSUB, OP_CMPADD: return 1'b1;
         default:              return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/dp_cond_check.sv
module dp_cond_check
   import dp_alu_pkg::*;
(
   input  logic [3:0] cond_code,
   input  flags_t     cur,
   output logic       pass
);

   always_comb begin
      unique case (cond_e'(cond_code))
         COND_EQ:     pass = cur.z;
         COND_NE:     pass = !cur.z;
         COND_UHS:    pass = cur.c;
         COND_ULO:    pass = !cur.c;
         COND_NEG:    pass = cur.n;
         COND_POS:    pass = !cur.n;
         COND_OVF:    pass = cur.v;
         COND_NOVF:   pass = !cur.v;
         COND_UHI:    pass = cur.c && !cur.z;
         COND_ULS:    pass = !cur.c || cur.z;
         COND_SGE:    pass = (cur.n == cur.v);
         COND_SLT:    pass = (cur.n != cur.v);
         COND_SGT:    pass = !cur.z && (cur.n == cur.v);
         COND_SLE:    pass = cur.z || (cur.n != cur.v);
         COND_ALWAYS: pass = 1'b1;
         default:     pass = 1'b0;
      endcase
   end

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
   import dp_alu_pkg::*;
#(
   parameter int W         = 32,
   parameter bit ZERO_TREE = 1'b0
) (
   input  op_e          op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         shc,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         is_arith,
   output logic         n_out,
   output logic         z_out,
   output logic         c_out,
   output logic         v_out
);

   localparam int CHUNK  = 8;
   localparam int NCHUNK = (W + CHUNK - 1) / CHUNK;
   localparam int PADW   = NCHUNK * CHUNK;

   logic [W-1:0] add_x, add_y;
   logic         add_ci;
   logic [W:0]   sum;

   // Operand steering onto one shared adder
   always_comb begin
      add_x  = a;
      add_y  = b;
      add_ci = 1'b0;
      unique case (op)
         OP_SUB, OP_CMPSUB: begin add_y = ~b; add_ci = 1'b1; end
         OP_RSUB:           begin add_x = b; add_y = ~a; add_ci = 1'b1; end
         OP_ADDC:           begin add_ci = cin; end
         OP_SUBC:           begin add_y = ~b; add_ci = cin; end
         OP_RSUBC:          begin add_x = b; add_y = ~a; add_ci = cin; end
         default:           begin end
      endcase
   end

   assign sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_ci};

   always_comb begin
      unique case (op)
         OP_AND, OP_TSTAND: res = a & b;
         OP_XOR, OP_TSTXOR: res = a ^ b;
         OP_OR:             res = a | b;
         OP_MOVE:           res = b;
         OP_CLR:            res = a & ~b;
         OP_MOVN:           res = ~b;
         default:           res = sum[W-1:0];
      endcase
   end

   assign is_arith = op_is_arith(op);
   assign n_out    = res[W-1];
   assign c_out    = is_arith ? sum[W] : shc;
   assign v_out    = (add_x[W-1] == add_y[W-1]) && (sum[W-1] != add_x[W-1]);

   generate
      if (ZERO_TREE) begin : g_zero_tree
         logic [PADW-1:0]   padded;
         logic [NCHUNK-1:0] chunk_any;
         always_comb begin
            padded        = '0;
            padded[W-1:0] = res;
         end
         for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
            assign chunk_any[k] = |padded[k*CHUNK +: CHUNK];
         end
         assign z_out = ~|chunk_any;
      end else begin : g_zero_flat
         assign z_out = (res == '0);
      end
   endgenerate

endmodule

// File: rtl/dp_flag_reg.sv
module dp_flag_reg
   import dp_alu_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  flags_t nxt,
   output flags_t cur
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cur <= '0;
      else if (load) cur <= nxt;
   end

endmodule

// File: rtl/dp_cond_alu.sv
module dp_cond_alu
   import dp_alu_pkg::*;
#(
   parameter int W         = 32,
   parameter bit ZERO_TREE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [3:0]   cond_code,
   input  logic [3:0]   opcode,
   input  logic         set_flags,
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   input  logic         shift_carry,
   output logic [W-1:0] result,
   output logic         rd_write,
   output logic [3:0]   flags
);

   generate
      if (W < 2) begin : g_bad_width
         $error("dp_cond_alu: W must be at least 2");
      end
   endgenerate

   op_e    op;
   flags_t cur_f, nxt_f;
   logic   pass, is_cmp, is_arith, load_f;
   logic   n_o, z_o, c_o, v_o;

   assign op     = op_e'(opcode);
   assign is_cmp = op_is_compare(op);

   dp_cond_check u_cond (
      .cond_code (cond_code),
      .cur       (cur_f),
      .pass      (pass)
   );

   dp_alu_core #(.W(W), .ZERO_TREE(ZERO_TREE)) u_core (
      .op       (op),
      .a        (opnd_a),
      .b        (opnd_b),
      .shc      (shift_carry),
      .cin      (cur_f.c),
      .res      (result),
      .is_arith (is_arith),
      .n_out    (n_o),
      .z_out    (z_o),
      .c_out    (c_o),
      .v_out    (v_o)
   );

   always_comb begin
      nxt_f.n = n_o;
      nxt_f.z = z_o;
      nxt_f.c = c_o;
      nxt_f.v = is_arith ? v_o : cur_f.v;
   end

   assign load_f   = pass && (set_flags || is_cmp);
   assign rd_write = pass && !is_cmp;

   dp_flag_reg u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_f),
      .nxt   (nxt_f),
      .cur   (cur_f)
   );

   assign flags = cur_f;

   AST_FAIL_NO_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) !pass |-> !rd_write); // R3
   AST_FAIL_KEEPS_NZCV: assert property (@(posedge clk) disable iff (!rst_n) !pass |=> $stable(flags)); // R3
   AST_NEVER_BLOCKS:   assert property (@(posedge clk) disable iff (!rst_n) (cond_code == 4'hF) |-> !pass); // R2
   AST_QUIET_KEEPS:    assert property (@(posedge clk) disable iff (!rst_n) (pass && !set_flags && !is_cmp) |=> $stable(flags)); // R4
   AST_CMP_NO_WRITE:   assert property (@(posedge clk) disable iff (!rst_n) is_cmp |-> !rd_write); // R4
   AST_N_FROM_MSB:     assert property (@(posedge clk) disable iff (!rst_n) load_f |=> flags[3] == $past(result[W-1])); // R5
   AST_LOGIC_V_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (!is_arith) |=> flags[0] == $past(flags[0])); // R7

endmodule

// File: tb/tb_dp_cond_alu.sv
module tb_dp_cond_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cond_code = 4'hF;
   logic [3:0]  opcode = 4'd13;
   logic        set_flags = 1'b0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        shift_carry = 1'b0;
   logic [31:0] result;
   logic        rd_write;
   logic [3:0]  flags;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dp_cond_alu dut (
      .clk (clk), .rst_n (rst_n), .cond_code (cond_code), .opcode (opcode),
      .set_flags (set_flags), .opnd_a (opnd_a), .opnd_b (opnd_b),
      .shift_carry (shift_carry), .result (result), .rd_write (rd_write),
      .flags (flags)
   );

   typedef struct packed {
      logic [3:0]  rq;
      logic [3:0]  cnd;
      logic [3:0]  op;
      logic        s;
      logic [31:0] a;
      logic [31:0] b;
      logic        shc;
      logic        we;
      logic [31:0] res;
      logic [3:0]  fl;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VEC [NV] = '{
      '{4'd7, 4'hE, 4'd4,  1'b1, 32'h7fffffff, 32'h00000001, 1'b0, 1'b1, 32'h80000000, 4'b1001}, // R7 add overflow
      '{4'd5, 4'hE, 4'd2,  1'b1, 32'h00000005, 32'h00000005, 1'b0, 1'b1, 32'h00000000, 4'b0110}, // R5 zero, no borrow
      '{4'd1, 4'h0, 4'd13, 1'b0, 32'h00000000, 32'h0000abcd, 1'b0, 1'b1, 32'h0000abcd, 4'b0110}, // R1 EQ passes
      '{4'd3, 4'h1, 4'd13, 1'b1, 32'h00000000, 32'h00001234, 1'b0, 1'b0, 32'h00000000, 4'b0110}, // R3 NE fails
      '{4'd6, 4'hE, 4'd5,  1'b1, 32'hffffffff, 32'h00000000, 1'b0, 1'b1, 32'h00000000, 4'b0110}, // R6 add carry in
      '{4'd6, 4'hE, 4'd6,  1'b1, 32'h00000010, 32'h00000003, 1'b0, 1'b1, 32'h0000000d, 4'b0010}, // R6 sbc C=1
      '{4'd6, 4'hE, 4'd3,  1'b1, 32'h00000005, 32'h00000003, 1'b0, 1'b1, 32'hfffffffe, 4'b1000}, // R6 reverse borrow
      '{4'd6, 4'hE, 4'd6,  1'b1, 32'h00000010, 32'h00000003, 1'b0, 1'b1, 32'h0000000c, 4'b0010}, // R6 sbc C=0
      '{4'd6, 4'hE, 4'd7,  1'b1, 32'h00000001, 32'h00000001, 1'b0, 1'b1, 32'h00000000, 4'b0110}, // R6 reverse with carry
      '{4'd9, 4'hE, 4'd8,  1'b0, 32'h000000f0, 32'h0000000f, 1'b0, 1'b0, 32'h00000000, 4'b0100}, // R9 and-test
      '{4'd1, 4'h2, 4'd4,  1'b1, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 32'h00000000, 4'b0100}, // R1 CS fails
      '{4'd9, 4'hE, 4'd10, 1'b0, 32'h80000000, 32'h00000001, 1'b0, 1'b0, 32'h00000000, 4'b0011}, // R9 compare overflow
      '{4'd8, 4'h6, 4'd1,  1'b1, 32'hffff0000, 32'h0f0f0f0f, 1'b1, 1'b1, 32'hf0f00f0f, 4'b1011}, // R8 xor, V kept
      '{4'd9, 4'hA, 4'd11, 1'b0, 32'hffffffff, 32'h00000001, 1'b1, 1'b0, 32'h00000000, 4'b0110}, // R9 compare-add, GE
      '{4'd8, 4'h9, 4'd14, 1'b1, 32'h0000000f, 32'h0000000a, 1'b0, 1'b1, 32'h00000005, 4'b0000}, // R8 bit clear, LS
      '{4'd2, 4'hB, 4'd12, 1'b1, 32'h00000001, 32'h00000002, 1'b1, 1'b0, 32'h00000000, 4'b0000}, // R2 LT fails
      '{4'd8, 4'hC, 4'd15, 1'b1, 32'h00000000, 32'h00000000, 1'b1, 1'b1, 32'hffffffff, 4'b1010}, // R8 move inverted, GT
      '{4'd2, 4'hD, 4'd0,  1'b1, 32'hffffffff, 32'h00000000, 1'b0, 1'b1, 32'h00000000, 4'b0100}, // R2 LE passes
      '{4'd1, 4'h4, 4'd13, 1'b1, 32'h00000000, 32'h00000007, 1'b0, 1'b0, 32'h00000000, 4'b0100}, // R1 MI fails
      '{4'd1, 4'h5, 4'd13, 1'b1, 32'h00000000, 32'h80000000, 1'b0, 1'b1, 32'h80000000, 4'b1000}, // R1 PL passes
      '{4'd1, 4'h3, 4'd13, 1'b0, 32'h00000000, 32'h00000001, 1'b1, 1'b1, 32'h00000001, 4'b1000}, // R1 CC passes
      '{4'd1, 4'h7, 4'd13, 1'b0, 32'h00000000, 32'h00000002, 1'b1, 1'b1, 32'h00000002, 4'b1000}, // R1 VC passes
      '{4'd2, 4'hF, 4'd13, 1'b1, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 32'h00000000, 4'b1000}, // R2 never
      '{4'd4, 4'hE, 4'd4,  1'b0, 32'hffffffff, 32'h00000001, 1'b1, 1'b1, 32'h00000000, 4'b1000}  // R4 no S, no update
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input vec_t v);
      @(negedge clk);
      cond_code = v.cnd; opcode = v.op; set_flags = v.s;
      opnd_a = v.a; opnd_b = v.b; shift_carry = v.shc;
      #2;
      chk($sformatf("R%0d write enable", v.rq), {31'b0, rd_write}, {31'b0, v.we});
      if (v.we) chk($sformatf("R%0d result", v.rq), result, v.res);
      @(posedge clk);
      #2;
      chk($sformatf("R%0d flags", v.rq), {28'b0, flags}, {28'b0, v.fl});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R10 flags in reset", {28'b0, flags}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      chk("R10 flags after reset", {28'b0, flags}, 32'h0);

      for (int i = 0; i < NV; i++) issue(VEC[i]);

      // R2: code 8 passes with C=1, Z=0 (set up by a subtract with no borrow)
      issue('{4'd6, 4'hE, 4'd2, 1'b1, 32'h9, 32'h4, 1'b0, 1'b1, 32'h5, 4'b0010});
      issue('{4'd2, 4'h8, 4'd13, 1'b0, 32'h0, 32'h77, 1'b0, 1'b1, 32'h77, 4'b0010});
      // R4: compare with S low must still update flags
      issue('{4'd4, 4'hE, 4'd9, 1'b0, 32'h5, 32'h5, 1'b1, 1'b0, 32'h0, 4'b0110});
      // R7: negative overflow on subtract
      issue('{4'd7, 4'hE, 4'd2, 1'b1, 32'h80000000, 32'h1, 1'b0, 1'b1, 32'h7fffffff, 4'b0011});
      // R10: reset mid-run clears the flags
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      chk("R10 async reset clears flags", {28'b0, flags}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule